// File: doc/BRIEF.md
# Memory Test Pattern Generator

This block supplies the data words for a memory self-test. Each time the test sequencer asks for a word, the generator returns one word of the class it is currently in. The sequencer uses this word as write data during a write pass and as expected data during a read pass. There are four classes: all zeros, all ones, an alternating checkerboard, and pseudo-random words from a linear congruential generator. A 4-bit enable input selects which classes take part. A step strobe moves the generator to the next enabled class in a fixed order. When no enabled class is left above the current one, it returns to the lowest enabled class and reports that the class cycle has wrapped.

The random state can be checkpointed and restored. The sequencer saves the state before a write pass and restores it before the matching read pass, so the read pass regenerates exactly the same random words. Every output is registered, and all results appear one clock after the strobe that causes them. The memory, the address counter and the compare logic sit outside this block.

Top module: `patgen_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cls_cur` is 4'b0001, `word_out` is 0, and `word_vld`, `cyc_wrap` and `en_err` are 0. The random state is 16'h0053, and the saved random state is also 16'h0053.
- R2: A `word_req` sampled at a clock edge, with a non-zero enable mask, makes `word_vld` high for exactly the next cycle, with the new word on `word_out`. With no request, `word_vld` is low and `word_out` keeps its previous value.
- R3: In class 4'b0001 (bit 0) each word is 16'h0000. In class 4'b0010 (bit 1) each word is 16'hFFFF.
- R4: In class 4'b0100 (bit 2) the words alternate 16'hAAAA, 16'h5555, 16'hAAAA, and so on. The first word after a toggle clear is 16'hAAAA. The toggle changes only when a checkerboard word is produced.
- R5: In class 4'b1000 (bit 3) each word is the new random state, x' = (2053*x + 16'h3619) mod 2^16. The state advances only when a random word is produced.
- R6: A `cls_step` moves `cls_cur` to the lowest enabled class whose bit is above the current one, skipping classes that are disabled.
- R7: If no enabled class lies above the current one, `cls_step` moves to the lowest enabled class. It also raises `cyc_wrap` for one cycle and clears the checkerboard toggle.
- R8: `cls_restart` moves to the lowest enabled class and clears the checkerboard toggle, without raising `cyc_wrap`. If it arrives together with `cls_step`, `cls_restart` wins.
- R9: `rnd_save` copies the current random state into the checkpoint. `rnd_restore` reloads the state from the checkpoint. If `rnd_restore` and a random-class `word_req` arrive in the same cycle, the word is computed from the checkpoint.
- R10: When `cls_en` is zero, `en_err` is high on the next cycle, and `word_req`, `cls_step` and `cls_restart` have no effect on any output.
- R11: `cls_cur` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_en | input | 4 | Enable mask per class (bit 0 zeros, 1 ones, 2 checker, 3 random); change only between strobes |
| word_req | input | 1 | Produce the next word of the current class |
| cls_step | input | 1 | Advance to the next enabled class |
| cls_restart | input | 1 | Return to the lowest enabled class |
| rnd_save | input | 1 | Checkpoint the random state |
| rnd_restore | input | 1 | Reload the random state from the checkpoint |
| cls_cur | output | 4 | One-hot current class |
| word_out | output | 16 | Generated data word |
| word_vld | output | 1 | `word_out` was updated by a request on the previous edge |
| cyc_wrap | output | 1 | One-cycle pulse after a class step wrapped around |
| en_err | output | 1 | Enable mask was zero on the previous edge |

## Verification
Every result is due on the first clock edge after its stimulus. This covers the new word and its valid pulse, the class change, the wrap pulse and the error flag; checkpoint effects show up in the first random word produced after them. The bench drives each stimulus on a falling edge and lets one rising edge pass. It samples all outputs a short time later, well before the next falling edge, so every check reads the value registered on that single edge. Random words are predicted in the bench with a plain multiply-and-add model rather than the shift-and-add form used in the design.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

  localparam int CLS_ZERO = 0;
  localparam int CLS_ONE  = 1;
  localparam int CLS_CHK  = 2;
  localparam int CLS_RND  = 3;

  // Alternating bit pattern: phase 0 sets odd bits (..1010), phase 1 even bits.
  function automatic logic [63:0] alt_bits(input int width, input logic phase);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < width; i++) begin
      v[i] = ((i % 2) == 1) ^ phase;
    end
    return v;
  endfunction

endpackage

// File: rtl/patgen_rotor.sv
module patgen_rotor #(
  parameter int NCLS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLS-1:0] en_mask,
  input  logic            step,
  input  logic            restart,
  output logic [NCLS-1:0] cur,
  output logic            wrap,
  output logic            err,
  output logic            mask_zero,
  output logic            clr_tog
);

  logic [NCLS-1:0] above;
  logic [NCLS-1:0] first_above;
  logic [NCLS-1:0] first_any;
  logic            none_above;

  assign mask_zero = (en_mask == '0);

  // Enabled classes strictly above the current one (trial bit shifted left).
  always_comb begin
    logic seen;
    seen  = 1'b0;
    above = '0;
    for (int i = 0; i < NCLS; i++) begin
      above[i] = en_mask[i] & seen;
      seen     = seen | cur[i];
    end
  end

  // Lowest set bit of each candidate set.
  always_comb begin
    logic got_a;
    logic got_b;
    got_a       = 1'b0;
    got_b       = 1'b0;
    first_above = '0;
    first_any   = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (above[i] && !got_a) begin
        first_above[i] = 1'b1;
        got_a          = 1'b1;
      end
      if (en_mask[i] && !got_b) begin
        first_any[i] = 1'b1;
        got_b        = 1'b1;
      end
    end
  end

  assign none_above = (above == '0);
  assign clr_tog    = !mask_zero && (restart || (step && none_above));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= {{(NCLS-1){1'b0}}, 1'b1};
      wrap <= 1'b0;
      err  <= 1'b0;
    end else begin
      wrap <= 1'b0;
      err  <= mask_zero;
      if (!mask_zero) begin
        if (restart) begin
          cur <= first_any;
        end else if (step) begin
          if (none_above) begin
            cur  <= first_any;
            wrap <= 1'b1;
          end else begin
            cur <= first_above;
          end
        end
      end
    end
  end

endmodule

// File: rtl/patgen_lcg.sv
module patgen_lcg #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'h0053,
  parameter logic [W-1:0] INC  = 16'h3619,
  parameter int          SH_A = 2,
  parameter int          SH_B = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic         save,
  input  logic         restore,
  output logic [W-1:0] x_next
);

  logic [W-1:0] x_q;
  logic [W-1:0] ckpt_q;
  logic [W-1:0] x_src;

  assign x_src  = restore ? ckpt_q : x_q;
  // Multiplier 1 + 2^SH_A + 2^SH_B built from adds and shifts.
  assign x_next = x_src + (x_src << SH_A) + (x_src << SH_B) + INC;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= SEED;
      ckpt_q <= SEED;
    end else begin
      if (save) begin
        ckpt_q <= x_q;
      end
      if (advance) begin
        x_q <= x_next;
      end else if (restore) begin
        x_q <= ckpt_q;
      end
    end
  end

endmodule

// File: rtl/patgen_top.sv
module patgen_top
  import patgen_pkg::*;
#(
  parameter int W    = 16,
  parameter int NCLS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLS-1:0] cls_en,
  input  logic            word_req,
  input  logic            cls_step,
  input  logic            cls_restart,
  input  logic            rnd_save,
  input  logic            rnd_restore,
  output logic [NCLS-1:0] cls_cur,
  output logic [W-1:0]    word_out,
  output logic            word_vld,
  output logic            cyc_wrap,
  output logic            en_err
);

  localparam logic [63:0] CHK_A_WIDE = alt_bits(W, 1'b0);
  localparam logic [63:0] CHK_B_WIDE = alt_bits(W, 1'b1);
  localparam logic [W-1:0] CHK_A = CHK_A_WIDE[W-1:0];
  localparam logic [W-1:0] CHK_B = CHK_B_WIDE[W-1:0];

  logic         mask_zero;
  logic         clr_tog;
  logic         gen;
  logic         tog_q;
  logic [W-1:0] rnd_word;
  logic [W-1:0] word_d;

  patgen_rotor #(.NCLS(NCLS)) u_rotor (
    .clk       (clk),
    .rst       (rst),
    .en_mask   (cls_en),
    .step      (cls_step),
    .restart   (cls_restart),
    .cur       (cls_cur),
    .wrap      (cyc_wrap),
    .err       (en_err),
    .mask_zero (mask_zero),
    .clr_tog   (clr_tog)
  );

  assign gen = word_req && !mask_zero;

  patgen_lcg #(.W(W)) u_lcg (
    .clk     (clk),
    .rst     (rst),
    .advance (gen && cls_cur[CLS_RND]),
    .save    (rnd_save),
    .restore (rnd_restore),
    .x_next  (rnd_word)
  );

  always_comb begin
    word_d = '0;
    unique case (1'b1)
      cls_cur[CLS_ONE]: word_d = '1;
      cls_cur[CLS_CHK]: word_d = tog_q ? CHK_B : CHK_A;
      cls_cur[CLS_RND]: word_d = rnd_word;
      default:          word_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q    <= 1'b0;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= gen;
      if (gen) begin
        word_out <= word_d;
      end
      if (clr_tog) begin
        tog_q <= 1'b0;
      end else if (gen && cls_cur[CLS_CHK]) begin
        tog_q <= ~tog_q;
      end
    end
  end

endmodule

// File: rtl/patgen_chk.sv
module patgen_chk #(
  parameter int W    = 16,
  parameter int NCLS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NCLS-1:0] cls_en,
  input logic            word_req,
  input logic            cls_step,
  input logic            cls_restart,
  input logic            rnd_save,
  input logic            rnd_restore,
  input logic [NCLS-1:0] cls_cur,
  input logic [W-1:0]    word_out,
  input logic            word_vld,
  input logic            cyc_wrap,
  input logic            en_err
);

  logic armed;
  always_ff @(posedge clk) begin
    armed <= !rst;
  end

  assert_cls_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(cls_cur) == 1);

  assert_vld_after_req_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    word_vld |-> $past(word_req));

  assert_word_held_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(word_req) |-> $stable(word_out));

  assert_err_blocks_word_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    en_err |-> !word_vld && !cyc_wrap);

  assert_wrap_after_step_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    cyc_wrap |-> $past(cls_step) && !$past(cls_restart));

  assert_ones_word_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (word_vld && $past(cls_cur[1])) |-> (word_out == '1));

  assert_chk_word_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    (word_vld && $past(cls_cur[2])) |->
      (word_out == 16'hAAAA || word_out == 16'h5555));

  logic unused_ok;
  assign unused_ok = ^{cls_en, rnd_save, rnd_restore};

endmodule

bind patgen_top patgen_chk #(.W(W), .NCLS(NCLS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cls_en      (cls_en),
  .word_req    (word_req),
  .cls_step    (cls_step),
  .cls_restart (cls_restart),
  .rnd_save    (rnd_save),
  .rnd_restore (rnd_restore),
  .cls_cur     (cls_cur),
  .word_out    (word_out),
  .word_vld    (word_vld),
  .cyc_wrap    (cyc_wrap),
  .en_err      (en_err)
);

// File: tb/patgen_top_tb.sv
module patgen_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cls_en = 4'hF;
  logic        word_req = 1'b0, cls_step = 1'b0, cls_restart = 1'b0;
  logic        rnd_save = 1'b0, rnd_restore = 1'b0;
  logic [3:0]  cls_cur;
  logic [15:0] word_out;
  logic        word_vld, cyc_wrap, en_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  patgen_top u_dut (
    .clk(clk), .rst(rst), .cls_en(cls_en), .word_req(word_req),
    .cls_step(cls_step), .cls_restart(cls_restart), .rnd_save(rnd_save),
    .rnd_restore(rnd_restore), .cls_cur(cls_cur), .word_out(word_out),
    .word_vld(word_vld), .cyc_wrap(cyc_wrap), .en_err(en_err)
  );

  // Vector: {mask[4], req, step, restart, exp_cls[4], exp_word[16], exp_vld, exp_wrap, exp_err}
  localparam int NV = 21;
  localparam logic [29:0] VEC [NV] = '{
    {4'hF, 3'b100, 4'b0001, 16'h0000, 3'b100},
    {4'hF, 3'b010, 4'b0010, 16'h0000, 3'b000},
    {4'hF, 3'b100, 4'b0010, 16'hFFFF, 3'b100},
    {4'hF, 3'b000, 4'b0010, 16'hFFFF, 3'b000},
    {4'hF, 3'b010, 4'b0100, 16'hFFFF, 3'b000},
    {4'hF, 3'b100, 4'b0100, 16'hAAAA, 3'b100},
    {4'hF, 3'b100, 4'b0100, 16'h5555, 3'b100},
    {4'hF, 3'b100, 4'b0100, 16'hAAAA, 3'b100},
    {4'hF, 3'b010, 4'b1000, 16'hAAAA, 3'b000},
    {4'h5, 3'b010, 4'b0001, 16'hAAAA, 3'b010},
    {4'h5, 3'b010, 4'b0100, 16'hAAAA, 3'b000},
    {4'h5, 3'b100, 4'b0100, 16'hAAAA, 3'b100},
    {4'h5, 3'b100, 4'b0100, 16'h5555, 3'b100},
    {4'h5, 3'b001, 4'b0001, 16'h5555, 3'b000},
    {4'h5, 3'b010, 4'b0100, 16'h5555, 3'b000},
    {4'h5, 3'b100, 4'b0100, 16'hAAAA, 3'b100},
    {4'h0, 3'b100, 4'b0100, 16'hAAAA, 3'b001},
    {4'h0, 3'b010, 4'b0100, 16'hAAAA, 3'b001},
    {4'h0, 3'b001, 4'b0100, 16'hAAAA, 3'b001},
    {4'hF, 3'b000, 4'b0100, 16'hAAAA, 3'b000},
    {4'h8, 3'b010, 4'b1000, 16'hAAAA, 3'b000}
  };
  // Requirement covered by each row (R2/R3/R4/R6/R7/R8/R10).
  localparam string VREQ [NV] = '{
    "R3", "R6", "R3", "R2", "R6", "R4", "R4", "R4", "R6", "R7", "R6",
    "R7", "R4", "R8", "R6", "R8", "R10", "R10", "R10", "R10", "R6"
  };

  function automatic logic [15:0] model_rnd(input logic [15:0] x);
    int unsigned p;
    p = 32'd2053 * x + 32'h3619;
    return p[15:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] m, input logic rq, input logic st,
                     input logic rs, input logic sv, input logic rr);
    @(negedge clk);
    cls_en = m; word_req = rq; cls_step = st; cls_restart = rs;
    rnd_save = sv; rnd_restore = rr;
    @(posedge clk);
    #2;
    word_req = 1'b0; cls_step = 1'b0; cls_restart = 1'b0;
    rnd_save = 1'b0; rnd_restore = 1'b0;
  endtask

  task automatic chk_rnd(input string req, input logic [15:0] exp);
    chk(req, "random word", word_out, exp);
    chk(req, "random valid", {15'd0, word_vld}, 16'd1);
  endtask

  task automatic chk_reset;
    chk("R1", "class", {12'd0, cls_cur}, 16'h0001);
    chk("R1", "word", word_out, 16'h0000);
    chk("R1", "flags", {13'd0, word_vld, cyc_wrap, en_err}, 16'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w1, w2, w3, w4;
    repeat (3) @(posedge clk);
    #2;
    chk_reset();
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    chk_reset();

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][29:26], VEC[i][25], VEC[i][24], VEC[i][23], 1'b0, 1'b0);
      chk(VREQ[i], "class", {12'd0, cls_cur}, {12'd0, VEC[i][22:19]});
      chk(VREQ[i], "word", word_out, VEC[i][18:3]);
      chk(VREQ[i], "vld/wrap/err", {13'd0, word_vld, cyc_wrap, en_err},
          {13'd0, VEC[i][2:0]});
    end

    // Random class (class 4'b1000); no random word produced yet, state at seed.
    w1 = model_rnd(16'h0053);
    w2 = model_rnd(w1);
    w3 = model_rnd(w2);
    w4 = model_rnd(w3);
    cyc(4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk_rnd("R5", w1);
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk_rnd("R5", w2);
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk_rnd("R5", w3);
    // restore together with a request: word comes from the checkpoint
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); chk_rnd("R9", w1);
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk_rnd("R9", w2);
    // checkpoint mid-sequence, run on, then replay
    cyc(4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk_rnd("R9", w3);
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk_rnd("R9", w4);
    cyc(4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9", "restore alone leaves word", word_out, w4);
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk_rnd("R9", w3);

    // Non-random words must not advance the random state
    cyc(4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7", "wrap from random", {11'd0, cls_cur, cyc_wrap}, {11'd0, 4'b0001, 1'b1});
    cyc(4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3", "zeros word", word_out, 16'h0000);
    cyc(4'h8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R8", "restart beats step", {11'd0, cls_cur, cyc_wrap}, {11'd0, 4'b1000, 1'b0});
    cyc(4'h8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk_rnd("R5", w4);

    // Reset mid-run restores seed and checkpoint
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    chk_reset();
    @(negedge clk); rst = 1'b0;
    cyc(4'h8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(4'h8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); chk_rnd("R1", w1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule